// File: doc/BRIEF.md
# Serial Bus Activity Watchdog

This block watches the clock and data lines of a two-wire serial bus and uses a particular pattern of bus traffic as proof that the host processor is still running. The pattern is a START condition, then at least one full low-then-high swing of the clock line, then a STOP condition. Each time this pattern completes, a timeout counter starts again from zero. If the selected period runs out first, the block raises a one-cycle timeout pulse, which a separate reset generator can act on. The counter then starts a new period.

Both bus lines are sampled with the system clock through synchronizer chains and then edge-detected. A two-bit period selector picks one of four tick counts, and a count of zero means the watchdog is off. Software writes the selector through a simple write strobe. A write-protect input freezes the selector while it is high. An external hold input keeps the counter at zero for as long as it is asserted.

Top module: `bus_watchdog`

## Requirements
- R1: While `rst` is high and in the cycle after it, `timeout_pulse` is 0. After reset, `period_sel` reads 2'b01.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both are judged on synchronized samples of the two lines.
- R3: A START, then SCL low and then high again, then a STOP forms a valid kick. The counter restarts at the fourth rising clock edge after the STOP's SDA edge reaches the pins.
- R4: A START followed by a STOP with no SCL low-high swing between them does not restart the counter.
- R5: A new START before the STOP clears any swing already seen, so the qualification begins again.
- R6: With no kick, `timeout_pulse` goes high for exactly one cycle, P cycles after the last restart, and then again every P cycles.
- R7: `period_sel` selects P as follows: 2'b00 turns the watchdog off (no pulse ever), 2'b01 gives 60, 2'b10 gives 150 and 2'b11 gives 400 (default parameters).
- R8: A `cfg_we` strobe with `wp_in` low loads `cfg_wdata` into `period_sel` at the next edge. With `wp_in` high the write is ignored and `period_sel` keeps its value.
- R9: An accepted write that changes `period_sel` restarts the counter at that same edge. A write of the value already held does not.
- R10: While `hold_in` is high, the counter stays at zero and no pulse is produced.
- R11: If a restart cause (kick, period change, hold) lands on the edge where the count would expire, the restart wins and no pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_in | input | 1 | Keeps the counter at zero while high |
| scl_in | input | 1 | Serial bus clock line (asynchronous) |
| sda_in | input | 1 | Serial bus data line (asynchronous) |
| wp_in | input | 1 | Write protect for the period selector |
| cfg_we | input | 1 | Write strobe for the period selector |
| cfg_wdata | input | 2 | New period selector value |
| period_sel | output | 2 | Current period selector |
| timeout_pulse | output | 1 | One-cycle pulse on expiry |

## Verification
A restart and an expiry can land on the same clock edge, and the restart has to win. The bench forces this directly: it releases `hold_in` and writes a new period selector exactly 60 edges later, which is the edge where the old period would expire. It then checks that no pulse appears and that the next pulse comes a full 150 cycles later. In the random phase, kicks with random gaps also land on expiry edges. There, every output cycle is compared with a bench model that gives any restart cause priority over the expiry.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef logic [1:0] per_sel_t;
  localparam per_sel_t SEL_OFF = 2'b00;
endpackage

// File: rtl/bw_sync.sv
module bw_sync #(
  parameter int STAGES = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{IDLE}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/bw_cond_det.sv
module bw_cond_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic start_det,
  output logic stop_det
);
  localparam int NLINES = 2;
  logic [NLINES-1:0] pins, synced, prev;

  assign pins = {scl_in, sda_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    bw_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk(clk), .rst(rst), .din(pins[g]), .dout(synced[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= synced;
  end

  assign scl_s     = synced[1];
  assign start_det = synced[1] & prev[1] & prev[0] & ~synced[0];
  assign stop_det  = synced[1] & prev[1] & ~prev[0] & synced[0];
endmodule

// File: rtl/bw_kick_qual.sv
module bw_kick_qual (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic start_det,
  input  logic stop_det,
  output logic kick
);
  logic armed, low_seen, swing_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      low_seen   <= 1'b0;
      swing_seen <= 1'b0;
      kick       <= 1'b0;
    end else begin
      kick <= stop_det & armed & swing_seen;
      if (start_det) begin
        armed      <= 1'b1;
        low_seen   <= 1'b0;
        swing_seen <= 1'b0;
      end else if (stop_det) begin
        armed      <= 1'b0;
        low_seen   <= 1'b0;
        swing_seen <= 1'b0;
      end else if (armed) begin
        if (!scl_s)        low_seen   <= 1'b1;
        else if (low_seen) swing_seen <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bw_period_reg.sv
module bw_period_reg
  import bw_pkg::*;
#(
  parameter per_sel_t SEL_RST = 2'b01
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     wp_in,
  input  logic     cfg_we,
  input  per_sel_t cfg_wdata,
  output per_sel_t sel,
  output logic     sel_change
);
  logic accept;

  assign accept     = cfg_we & ~wp_in;
  assign sel_change = accept & (cfg_wdata != sel);

  always_ff @(posedge clk) begin
    if (rst)         sel <= SEL_RST;
    else if (accept) sel <= cfg_wdata;
  end
endmodule

// File: rtl/bw_timer.sv
module bw_timer
  import bw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PER0  = 0,
  parameter int PER1  = 60,
  parameter int PER2  = 150,
  parameter int PER3  = 400
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hold_in,
  input  logic     kick,
  input  logic     sel_change,
  input  per_sel_t sel,
  output logic     timeout_pulse
);
  localparam logic [CNT_W-1:0] L0 = CNT_W'(PER0);
  localparam logic [CNT_W-1:0] L1 = CNT_W'(PER1);
  localparam logic [CNT_W-1:0] L2 = CNT_W'(PER2);
  localparam logic [CNT_W-1:0] L3 = CNT_W'(PER3);

  logic [CNT_W-1:0] cnt, limit;
  logic             restart;

  always_comb begin
    case (sel)
      2'b00:   limit = L0;
      2'b01:   limit = L1;
      2'b10:   limit = L2;
      default: limit = L3;
    endcase
  end

  assign restart = hold_in | kick | sel_change;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt           <= '0;
      timeout_pulse <= 1'b0;
    end else if (limit == '0) begin
      cnt           <= '0;
      timeout_pulse <= 1'b0;
    end else if (cnt == limit - 1'b1) begin
      cnt           <= '0;
      timeout_pulse <= 1'b1;
    end else begin
      cnt           <= cnt + 1'b1;
      timeout_pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import bw_pkg::*;
#(
  parameter int       SYNC_STAGES = 2,
  parameter int       CNT_W       = 16,
  parameter int       PER0        = 0,
  parameter int       PER1        = 60,
  parameter int       PER2        = 150,
  parameter int       PER3        = 400,
  parameter per_sel_t SEL_RST     = 2'b01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_in,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       wp_in,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] period_sel,
  output logic       timeout_pulse
);
  logic scl_s, start_det, stop_det, kick, sel_change;

  bw_cond_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det)
  );

  bw_kick_qual u_qual (
    .clk(clk), .rst(rst), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .kick(kick)
  );

  bw_period_reg #(.SEL_RST(SEL_RST)) u_preg (
    .clk(clk), .rst(rst), .wp_in(wp_in), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .sel(period_sel), .sel_change(sel_change)
  );

  bw_timer #(
    .CNT_W(CNT_W), .PER0(PER0), .PER1(PER1), .PER2(PER2), .PER3(PER3)
  ) u_timer (
    .clk(clk), .rst(rst), .hold_in(hold_in), .kick(kick),
    .sel_change(sel_change), .sel(period_sel), .timeout_pulse(timeout_pulse)
  );
endmodule

// File: rtl/bw_checker.sv
module bw_checker (
  input logic       clk,
  input logic       rst,
  input logic       hold_in,
  input logic       wp_in,
  input logic       cfg_we,
  input logic [1:0] cfg_wdata,
  input logic [1:0] period_sel,
  input logic       kick_pulse,
  input logic       timeout_pulse
);
  // R6: a pulse lasts exactly one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |=> !timeout_pulse);

  // R1: no pulse in the cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !timeout_pulse);

  // R8: write protect freezes the selector
  a_r8_wp_freeze: assert property (@(posedge clk) disable iff (rst)
    wp_in |=> $stable(period_sel));

  // R7: selector 00 means no pulse
  a_r7_off_silent: assert property (@(posedge clk) disable iff (rst)
    (period_sel == 2'b00) |=> !timeout_pulse);

  // R10: hold suppresses pulses
  a_r10_hold_silent: assert property (@(posedge clk) disable iff (rst)
    hold_in |=> !timeout_pulse);

  // R9 / R11: an accepted change restarts, no pulse at that edge
  a_r9_change_restarts: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !wp_in && (cfg_wdata != period_sel)) |=> !timeout_pulse);

  // R3 / R11: a kick wins over expiry
  a_r11_kick_wins: assert property (@(posedge clk) disable iff (rst)
    kick_pulse |=> !timeout_pulse);
endmodule

bind bus_watchdog bw_checker u_chk (
  .clk(clk), .rst(rst), .hold_in(hold_in), .wp_in(wp_in),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .period_sel(period_sel),
  .kick_pulse(kick), .timeout_pulse(timeout_pulse)
);

// File: tb/sim_bus_watchdog.sv
module sim_bus_watchdog;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold_in = 1'b0;
  logic       scl_in = 1'b1;
  logic       sda_in = 1'b1;
  logic       wp_in = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_wdata = 2'b00;
  logic [1:0] period_sel;
  logic       timeout_pulse;

  int total = 0;
  int fails = 0;
  int dut_pulses = 0;
  int mod_pulses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_watchdog u0 (
    .clk(clk), .rst(rst), .hold_in(hold_in), .scl_in(scl_in), .sda_in(sda_in),
    .wp_in(wp_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .period_sel(period_sel), .timeout_pulse(timeout_pulse)
  );

  // Reference model built from the requirements
  function automatic int exp_period(input logic [1:0] s);
    case (s)
      2'b00:   return 0;
      2'b01:   return 60;
      2'b10:   return 150;
      default: return 400;
    endcase
  endfunction

  logic [1:0] ms1, ms2, mq;   // [1]=SCL, [0]=SDA
  logic       m_arm, m_low, m_swing, m_kick, m_tout;
  logic [1:0] m_sel;
  int         m_cnt;
  logic       m_start, m_stop, m_chg;

  assign m_start = ms2[1] & mq[1] & mq[0] & ~ms2[0];
  assign m_stop  = ms2[1] & mq[1] & ~mq[0] & ms2[0];
  assign m_chg   = cfg_we & ~wp_in & (cfg_wdata != m_sel);

  always @(posedge clk) begin
    if (rst) begin
      ms1 <= 2'b11; ms2 <= 2'b11; mq <= 2'b11;
      m_arm <= 0; m_low <= 0; m_swing <= 0; m_kick <= 0;
      m_tout <= 0; m_cnt <= 0; m_sel <= 2'b01;
    end else begin
      ms1 <= {scl_in, sda_in};
      ms2 <= ms1;
      mq  <= ms2;
      m_kick <= m_stop & m_arm & m_swing;
      if (m_start) begin
        m_arm <= 1; m_low <= 0; m_swing <= 0;
      end else if (m_stop) begin
        m_arm <= 0; m_low <= 0; m_swing <= 0;
      end else if (m_arm) begin
        if (!ms2[1]) m_low <= 1;
        else if (m_low) m_swing <= 1;
      end
      if (cfg_we && !wp_in) m_sel <= cfg_wdata;
      if (hold_in || m_kick || m_chg) begin
        m_cnt <= 0; m_tout <= 0;
      end else if (exp_period(m_sel) == 0) begin
        m_cnt <= 0; m_tout <= 0;
      end else if (m_cnt == exp_period(m_sel) - 1) begin
        m_cnt <= 0; m_tout <= 1;
      end else begin
        m_cnt <= m_cnt + 1; m_tout <= 0;
      end
    end
  end

  // Cycle-by-cycle comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (timeout_pulse) dut_pulses++;
      if (m_tout) mod_pulses++;
      total++;
      if (timeout_pulse !== m_tout) begin
        fails++;
        $display("FAIL R6 cycle timeout_pulse act=%0b exp=%0b t=%0t", timeout_pulse, m_tout, $time);
      end
      total++;
      if (period_sel !== m_sel) begin
        fails++;
        $display("FAIL R8 cycle period_sel act=%0b exp=%0b t=%0t", period_sel, m_sel, $time);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(input logic c, input logic d, input int n);
    scl_in = c; sda_in = d;
    ticks(n);
  endtask

  task automatic cfg_write(input logic [1:0] d);
    cfg_we = 1'b1; cfg_wdata = d;
    ticks(1);
    cfg_we = 1'b0;
  endtask

  task automatic good_kick(input int w);
    step(1, 0, w); step(0, 0, w); step(1, 0, w); step(1, 1, w);
  endtask

  task automatic bare_kick(input int w);
    step(1, 0, w); step(1, 1, w);
  endtask

  task automatic restart_kick(input int w);
    step(1, 0, w); step(0, 0, w); step(1, 0, w); step(0, 0, w);
    step(0, 1, w); step(1, 1, w); step(1, 0, w); step(1, 1, w);
  endtask

  task automatic finish_run;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    int d0, m0;
    void'($urandom(32'd1234));
    ticks(4);
    #1;
    check("R1 pulse in reset", int'(timeout_pulse), 0);
    check("R1 selector reset value", int'(period_sel), 1);
    rst = 1'b0;
    ticks(1); #1;
    check("R1 pulse after reset", int'(timeout_pulse), 0);

    // R6: free-running period 60
    d0 = dut_pulses;
    ticks(199); #1;
    check("R6 pulses in 200 idle cycles", dut_pulses - d0, 3);

    // R8: write accepted, then locked
    cfg_write(2'b10); #1;
    check("R8 write accepted", int'(period_sel), 2);
    wp_in = 1'b1;
    cfg_write(2'b11); #1;
    check("R8 write ignored under wp", int'(period_sel), 2);
    wp_in = 1'b0;

    // R7: off encoding
    cfg_write(2'b00);
    d0 = dut_pulses;
    ticks(500); #1;
    check("R7 selector 00 silent", dut_pulses - d0, 0);

    // R9: same-value write does not restart
    cfg_write(2'b01);
    ticks(30);
    cfg_write(2'b01);
    d0 = dut_pulses;
    ticks(35); #1;
    check("R9 same write keeps count", dut_pulses - d0, 1);

    // R2/R3: valid kicks keep the watchdog quiet
    d0 = dut_pulses;
    for (int i = 0; i < 10; i++) begin good_kick(4); ticks(20); end
    #1;
    check("R2/R3 valid kicks no pulse", dut_pulses - d0, 0);

    // R4: START then STOP without a swing
    d0 = dut_pulses; m0 = mod_pulses;
    for (int i = 0; i < 10; i++) begin bare_kick(4); ticks(20); end
    #1;
    check("R4 bare kicks ignored", int'((dut_pulses - d0) >= 4), 1);
    check("R4 pulse count vs model", dut_pulses - d0, mod_pulses - m0);

    // R5: repeated START clears the swing
    d0 = dut_pulses; m0 = mod_pulses;
    for (int i = 0; i < 6; i++) begin restart_kick(3); ticks(16); end
    #1;
    check("R5 restart clears swing", int'((dut_pulses - d0) >= 3), 1);
    check("R5 pulse count vs model", dut_pulses - d0, mod_pulses - m0);

    // R10: hold
    hold_in = 1'b1;
    d0 = dut_pulses;
    ticks(300); #1;
    check("R10 hold silent", dut_pulses - d0, 0);

    // R11: period change on the expiry edge
    hold_in = 1'b0;
    ticks(59);
    cfg_write(2'b10); #1;
    check("R11 change beats expiry", int'(timeout_pulse), 0);
    d0 = dut_pulses;
    ticks(160); #1;
    check("R7 period 150 after change", dut_pulses - d0, 1);

    // R7: period 400
    cfg_write(2'b11);
    d0 = dut_pulses;
    ticks(410); #1;
    check("R7 period 400", dut_pulses - d0, 1);

    // Random mix
    cfg_write(2'b01);
    d0 = dut_pulses; m0 = mod_pulses;
    for (int i = 0; i < 120; i++) begin
      case ($urandom % 5)
        0: good_kick(3 + int'($urandom % 3));
        1: bare_kick(3 + int'($urandom % 3));
        2: restart_kick(3);
        3: begin
             wp_in = 1'($urandom % 2);
             cfg_write(2'($urandom % 4));
             wp_in = 1'b0;
           end
        default: ticks(1);
      endcase
      if (($urandom % 8) == 0) cfg_write(2'b01);
      ticks(int'($urandom % 70));
    end
    #1;
    check("R11 random pulse count vs model", dut_pulses - d0, mod_pulses - m0);

    finish_run();
  end
endmodule